// File: doc/BRIEF.md
# Write-Status Read-Back Multiplexer

This block forms the read side of a byte-wide non-volatile memory model. A read is qualified when chip enable and output enable are both low and write enable is high. In that state the block drives the byte supplied by the storage array onto the data bus. In every other state the bus is left floating, which is modelled by a per-bit drive-enable vector that is all zero.

While the write sequencer has a page-load window open or a programming cycle running, normal read data is replaced by a status byte. The upper three bits of that byte let a host find out when the write has finished without a dedicated pin. The top bit is a data-polling bit that returns the complement of the top bit of the last byte written. The next bit toggles on successive reads. The bit below it shows whether the byte-load timer is still running. The five low bits are not driven.

The write sequencer supplies three inputs: a programming-busy flag, a load-timer-running flag, and the top bit of the last written byte. The outputs respond combinationally to the bus controls. Only the toggle state is held in registers.

Top module: `wstat_readback`

## Requirements
- R1: When ce_n is high, oe_n is high or we_n is low, dq_oe is all zero and dq_out is all zero.
- R2: During a qualified read with prog_busy and load_run both low, dq_out equals arr_data and every bit of dq_oe is 1, in the same cycle.
- R3: During a qualified read with prog_busy or load_run high, dq_out bit 7 is the inverse of last_wr_msb. Once both flags are low, bit 7 again shows the stored value from arr_data.
- R4: In status mode, dq_out bit 6 flips once each time a qualified read ends, meaning the read condition is true in one cycle and false in the next while status mode holds. It stays constant for the whole length of a single read.
- R5: Bit 6 reads 0 in the cycle prog_busy rises and is cleared whenever status mode is off, so toggling stops when the cycle completes and the first status read of a new programming cycle returns 0.
- R6: In status mode, dq_out bit 5 is 0 while load_run is high and 1 while it is low.
- R7: During a status read, dq_oe bits 7 to 5 are 1 and dq_oe bits 4 to 0 are 0, with dq_out bits 4 to 0 at 0.
- R8: While rst_n is low, the toggle state is 0, so a status read returns 0 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| prog_busy | input | 1 | Programming cycle in progress, from the write sequencer |
| load_run | input | 1 | Byte-load timer running, from the write sequencer |
| last_wr_msb | input | 1 | Bit 7 of the last byte written |
| arr_data | input | DATA_W | Stored byte at the current address |
| dq_out | output | DATA_W | Byte presented on the bus |
| dq_oe | output | DATA_W | Per-bit drive enable, 1 = driven |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the three status bits sit at positions 7, 6 and 5, and exactly five low bits must stay undriven during status reads. Directed phases cover the following cases:
- reads that end exactly as the load window hands over to programming;
- reads held across the rise of the busy flag;
- back-to-back read pulses separated by a single idle cycle.

A long mixed phase then holds the busy and timer flags for random stretches. Throughout, a behavioural toggle model is compared with the outputs on every clock.

// File: rtl/wstat_readback_pkg.sv
package wstat_readback_pkg;

    // Registered state of the toggle tracker
    typedef struct packed {
        logic rd_act;   // read condition in the previous cycle
        logic busy;     // programming flag in the previous cycle
        logic tog;      // current toggle value
    } trk_state_t;

endpackage

// File: rtl/wstat_readback_qual.sv
module wstat_readback_qual (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic read_act
);
    // Qualified read: both enables low, write enable high
    always_comb begin
        read_act = ~ce_n & ~oe_n & we_n;
    end
endmodule

// File: rtl/wstat_readback_toggle.sv
module wstat_readback_toggle
    import wstat_readback_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic read_act,
    input  logic status_on,
    input  logic prog_busy,
    output logic tog_bit
);
    trk_state_t st_d, st_q;
    logic       prog_start;
    logic       read_end;

    always_comb begin
        prog_start = prog_busy & ~st_q.busy;
        read_end   = st_q.rd_act & ~read_act;
        st_d        = st_q;
        st_d.rd_act = read_act;
        st_d.busy   = prog_busy;
        if (!status_on || prog_start) begin
            st_d.tog = 1'b0;
        end else if (read_end) begin
            st_d.tog = ~st_q.tog;
        end
        // a freshly started programming cycle always reports 0 first
        tog_bit = st_q.tog & ~prog_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wstat_readback_fmt.sv
module wstat_readback_fmt #(
    parameter int DATA_W = 8
) (
    input  logic              read_act,
    input  logic              status_on,
    input  logic              load_run,
    input  logic              last_wr_msb,
    input  logic              tog_bit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;
    localparam int TMR_POS  = DATA_W - 3;

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (read_act) begin
            if (status_on) begin
                for (int b = 0; b < DATA_W; b++) begin
                    dq_oe[b] = (b >= TMR_POS);
                end
                dq_out[POLL_POS] = ~last_wr_msb;
                dq_out[TOG_POS]  = tog_bit;
                dq_out[TMR_POS]  = ~load_run;
            end else begin
                dq_out = arr_data;
                dq_oe  = '1;
            end
        end
    end
endmodule

// File: rtl/wstat_readback.sv
module wstat_readback #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              prog_busy,
    input  logic              load_run,
    input  logic              last_wr_msb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    logic read_act;
    logic status_on;
    logic tog_bit;

    always_comb begin
        status_on = prog_busy | load_run;
    end

    wstat_readback_qual u_qual (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .read_act (read_act)
    );

    wstat_readback_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_act  (read_act),
        .status_on (status_on),
        .prog_busy (prog_busy),
        .tog_bit   (tog_bit)
    );

    wstat_readback_fmt #(.DATA_W(DATA_W)) u_fmt (
        .read_act    (read_act),
        .status_on   (status_on),
        .load_run    (load_run),
        .last_wr_msb (last_wr_msb),
        .tog_bit     (tog_bit),
        .arr_data    (arr_data),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );
endmodule

// File: rtl/wstat_readback_chk.sv
module wstat_readback_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              prog_busy,
    input logic              load_run,
    input logic              last_wr_msb,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] dq_out,
    input logic [DATA_W-1:0] dq_oe
);
    logic rd;
    logic st;
    always_comb begin
        rd = !ce_n && !oe_n && we_n;
        st = prog_busy || load_run;
    end

    AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (dq_oe == '0));  // R1
    AST_NORMAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !st) |-> (dq_out == arr_data && dq_oe == '1));  // R2
    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && st) |-> (dq_out[DATA_W-1] == !last_wr_msb));  // R3
    AST_TOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $past(rd) && st && $past(st) && !$rose(prog_busy)) |-> $stable(dq_out[DATA_W-2]));  // R4
    AST_TOG_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $rose(prog_busy)) |-> (dq_out[DATA_W-2] == 1'b0));  // R5
    AST_TIMER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && st) |-> (dq_out[DATA_W-3] == !load_run));  // R6
    AST_LOW_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && st) |-> (dq_oe[DATA_W-4:0] == '0 && dq_oe[DATA_W-1:DATA_W-3] == '1));  // R7
endmodule

bind wstat_readback wstat_readback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .prog_busy(prog_busy), .load_run(load_run), .last_wr_msb(last_wr_msb),
    .arr_data(arr_data), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/wstat_readback_tb.sv
module wstat_readback_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ce_n, oe_n, we_n, prog_busy, load_run, last_wr_msb;
    logic [7:0] arr_data, dq_out, dq_oe;

    always #5 clk = ~clk;

    wstat_readback #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .prog_busy(prog_busy), .load_run(load_run), .last_wr_msb(last_wr_msb),
        .arr_data(arr_data), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    int tog_m = 0;
    bit prev_rd_m = 0;
    bit prev_busy_m = 0;
    bit done = 0;

    // behavioural toggle model, updated on each clock from settled inputs
    always @(posedge clk) begin
        bit rd_now, st_now;
        rd_now = !ce_n && !oe_n && we_n;
        st_now = prog_busy || load_run;
        if (!rst_n) begin
            tog_m = 0; prev_rd_m = 0; prev_busy_m = 0;
        end else begin
            if (!st_now || (prog_busy && !prev_busy_m)) tog_m = 0;  // R5
            else if (prev_rd_m && !rd_now) tog_m = 1 - tog_m;     // R4
            prev_rd_m = rd_now;
            prev_busy_m = prog_busy;
        end
    end

    task automatic check_now(input string phase);
        logic [7:0] e_out, e_oe;
        bit rd_now, st_now;
        string tag;
        rd_now = !ce_n && !oe_n && we_n;
        st_now = prog_busy || load_run;
        e_out = 8'h00; e_oe = 8'h00;
        if (!rd_now) tag = "R1";
        else if (!st_now) begin
            tag = "R2"; e_out = arr_data; e_oe = 8'hFF;
        end else begin
            tag = (!rst_n) ? "R8" : "R3/R4/R5/R6/R7";
            e_oe = 8'hE0;
            e_out[7] = !last_wr_msb;
            e_out[6] = (prog_busy && !prev_busy_m) ? 1'b0 : tog_m[0];
            e_out[5] = !load_run;
        end
        n_vec++;
        if (dq_out !== e_out || dq_oe !== e_oe) begin
            n_bad++;
            $display("FAIL %s [%s] out=%h/oe=%h expected out=%h/oe=%h",
                     tag, phase, dq_out, dq_oe, e_out, e_oe);
        end
    endtask

    task automatic step(input bit c, input bit o, input bit w, input bit b,
                        input bit l, input bit m, input logic [7:0] d, input string phase);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; prog_busy = b; load_run = l;
        last_wr_msb = m; arr_data = d;
        #1 check_now(phase);
    endtask

    // one read pulse of len cycles followed by one idle cycle
    task automatic pulse(input int len, input bit b, input bit l, input bit m,
                         input logic [7:0] d, input string phase);
        for (int i = 0; i < len; i++) step(0, 0, 1, b, l, m, d, phase);
        step(0, 1, 1, b, l, m, d, phase);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; prog_busy = 0; load_run = 0;
        last_wr_msb = 0; arr_data = 8'h00;
        // R8: status read held in reset shows toggle 0
        step(0, 0, 1, 0, 1, 1, 8'h3C, "R8 reset status");
        step(0, 1, 1, 0, 1, 1, 8'h3C, "R8 reset idle");
        step(0, 0, 1, 0, 1, 1, 8'h3C, "R8 reset status again");
        @(negedge clk); rst_n = 1;
        // R1: undriven combinations
        step(1, 0, 1, 0, 0, 0, 8'hA5, "R1 ce high");
        step(0, 1, 1, 0, 0, 0, 8'hA5, "R1 oe high");
        step(0, 0, 0, 0, 0, 0, 8'hA5, "R1 we low");
        step(1, 1, 0, 1, 1, 0, 8'hA5, "R1 all off in status");
        // R2: normal reads
        step(0, 0, 1, 0, 0, 0, 8'hA5, "R2 read A5");
        step(0, 0, 1, 0, 0, 1, 8'h5A, "R2 read 5A");
        step(0, 0, 1, 0, 0, 0, 8'hFF, "R2 read FF");
        step(0, 0, 1, 0, 0, 0, 8'h00, "R2 read 00");
        // R4/R6: load window, timer running, toggle advances per read
        for (int k = 0; k < 4; k++) pulse(1 + k, 0, 1, 1, 8'h80, "R4 R6 load window");
        // R5: busy rises mid read, then toggle restarts at 0
        step(0, 0, 1, 0, 1, 0, 8'h80, "R5 before start");
        step(0, 0, 1, 1, 0, 0, 8'h80, "R5 busy rise in read");
        step(0, 0, 1, 1, 0, 0, 8'h80, "R5 held read");
        step(0, 1, 1, 1, 0, 0, 8'h80, "R5 read end");
        for (int k = 0; k < 6; k++) pulse(1 + (k % 3), 1, 0, k[0], 8'h11, "R3 R4 R7 programming");
        // R3/R5: completion, true value and no toggling
        pulse(2, 0, 0, 0, 8'h91, "R3 R5 done true value");
        pulse(2, 0, 0, 0, 8'h91, "R5 toggle stopped");
        // second programming cycle starts at 0 again
        step(0, 1, 1, 1, 0, 1, 8'h22, "R5 second start");
        pulse(1, 1, 0, 1, 8'h22, "R5 first read of new cycle");
        pulse(1, 1, 0, 1, 8'h22, "R4 second read");
        // mixed stretches
        begin
            bit b = 0, l = 0, m = 0;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 15) == 0) b = !b;
                if ($urandom_range(0, 11) == 0) l = !l;
                if ($urandom_range(0, 7) == 0) m = !m;
                step($urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
                     $urandom_range(0, 7) != 0, b, l, m, 8'($urandom), "mixed");
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule